// File: doc/BRIEF.md
# Single-Step Non-Restoring Divider

This block performs one step of a 32-bit non-restoring division each time its step strobe is high. It keeps three status flags: M (divisor sign), Q (running quotient/remainder sign) and T (the quotient bit just produced). It also keeps a result register that holds the updated partial remainder. On each step the partial remainder at the input is shifted left by one bit, and T fills the vacated bit. Then the divisor is either subtracted or added, as the stored Q and M decide. Q and T are then recomputed from the bit that was shifted out and from the carry or borrow of that add or subtract.

An external sequencer sets up the flags through a flag-load strobe. For unsigned division it clears all three flags. It then issues the step repeatedly, feeding the returned remainder back in and collecting each new quotient bit from T. The sequencer also owns the iteration count and the quotient register, and it places the next dividend bit into T before each step.

Top module: `nr_div_step`

## Requirements
- R1: While reset is asserted, and after it is released, the result output and the M, Q and T outputs are all zero until the first load or step.
- R2: When the flag-load strobe is high at a clock edge, M, Q and T take the values of the three flag inputs at that edge, and the result output holds its value.
- R3: When the flag-load and step strobes are both high at one edge, the load takes effect and the step is ignored: the result output holds its value.
- R4: A step shifts the partial remainder input left by one bit, with the stored T entering bit 0. With a zero divisor, the result equals that shifted value.
- R5: When the stored Q equals the stored M, a step subtracts the divisor from the shifted value.
- R6: When the stored Q differs from the stored M, a step adds the divisor to the shifted value.
- R7: After a step, Q equals bit 31 of the partial remainder input XOR the stored M XOR the borrow of the subtract or the carry of the add.
- R8: After a step, T is 1 when the new Q equals M, and 0 otherwise.
- R9: A step leaves M unchanged.
- R10: With neither strobe high, the result output and all flags hold, whatever the data inputs do.
- R11: The add and the subtract wrap modulo 2^32.
- R12: Start with M=Q=T=0 and a partial remainder (high dividend word) smaller than the divisor. Then run 32 rounds, each placing the next dividend bit (MSB first) into T and then stepping. The 32 T values, MSB first, form the unsigned quotient of the 64-bit dividend by the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_i | input | 1 | Perform one division step at this edge |
| load_i | input | 1 | Load M, Q, T from the flag inputs at this edge (wins over step) |
| m_i | input | 1 | M value to load |
| q_i | input | 1 | Q value to load |
| t_i | input | 1 | T value to load |
| divisor_i | input | 32 | Divisor operand |
| rem_i | input | 32 | Partial remainder operand |
| rem_o | output | 32 | Updated partial remainder (registered) |
| m_o | output | 1 | Stored M flag |
| q_o | output | 1 | Stored Q flag |
| t_o | output | 1 | Stored T flag (latest quotient bit) |

## Verification
The bench drives all four combinations of stored Q and M. A design with the add/subtract choice inverted, or with the Q update missing an XOR term, would return a wrong remainder or wrong flags on at least one of them. Operands are chosen to wrap both ways across 2^32. This exposes a carry or borrow that was computed from the wrong comparison direction, or one that was dropped. A zero divisor isolates the shift, so a design that drops T into the low bit, or loses it, shows up directly. Simultaneous load and step checks that the step is ignored. Full 32-round unsigned divisions, including an all-ones divisor, catch any error that only builds up across iterations.

// File: rtl/nr_div_step_pkg.sv
package nr_div_step_pkg;
  // Status flags of the divider step
  typedef struct packed {
    logic m;
    logic q;
    logic t;
  } dflags_t;

  localparam dflags_t DFLAGS_ZERO = '{m: 1'b0, q: 1'b0, t: 1'b0};
endpackage

// File: rtl/nr_rst_sync.sv
module nr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/nr_step_shift.sv
module nr_step_shift #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_in,
  input  logic         fill_bit,
  output logic [W-1:0] shifted,
  output logic         out_bit
);
  localparam int TOP = W - 1;

  assign out_bit = rem_in[TOP];
  assign shifted = {rem_in[TOP-1:0], fill_bit};
endmodule

// File: rtl/nr_step_addsub.sv
module nr_step_addsub #(
  parameter int W          = 32,
  parameter bit WIDE_ADDER = 1'b1
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         do_sub,
  output logic [W-1:0] sum,
  output logic         cy
);
  generate
    if (WIDE_ADDER) begin : g_wide
      // One extra bit holds the carry out or the borrow out
      logic [W:0] ext;
      always_comb begin
        if (do_sub) ext = {1'b0, opa} - {1'b0, opb};
        else        ext = {1'b0, opa} + {1'b0, opb};
      end
      assign sum = ext[W-1:0];
      assign cy  = ext[W];
    end else begin : g_cmp
      // Wrapping result, then an unsigned compare against the input
      logic [W-1:0] raw;
      always_comb begin
        if (do_sub) raw = opa - opb;
        else        raw = opa + opb;
      end
      assign sum = raw;
      assign cy  = do_sub ? (raw > opa) : (raw < opa);
    end
  endgenerate
endmodule

// File: rtl/nr_step_flags.sv
module nr_step_flags (
  input  logic out_bit,
  input  logic m_cur,
  input  logic cy,
  output logic q_new,
  output logic t_new
);
  always_comb begin
    q_new = out_bit ^ m_cur ^ cy;
    t_new = (q_new == m_cur);
  end
endmodule

// File: rtl/nr_div_step.sv
module nr_div_step
  import nr_div_step_pkg::*;
#(
  parameter int W          = 32,
  parameter bit WIDE_ADDER = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic         load_i,
  input  logic         m_i,
  input  logic         q_i,
  input  logic         t_i,
  input  logic [W-1:0] divisor_i,
  input  logic [W-1:0] rem_i,
  output logic [W-1:0] rem_o,
  output logic         m_o,
  output logic         q_o,
  output logic         t_o
);
  logic         srst_n;
  dflags_t      flg_q, flg_d;
  logic [W-1:0] rem_q, rem_d;
  logic [W-1:0] shifted, sum;
  logic         out_bit, cy, do_sub, q_new, t_new, upd_en;

  nr_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  nr_step_shift #(.W(W)) u_shift (
    .rem_in   (rem_i),
    .fill_bit (flg_q.t),
    .shifted  (shifted),
    .out_bit  (out_bit)
  );

  // Matching Q and M selects subtract, otherwise add
  assign do_sub = (flg_q.q == flg_q.m);

  nr_step_addsub #(.W(W), .WIDE_ADDER(WIDE_ADDER)) u_addsub (
    .opa    (shifted),
    .opb    (divisor_i),
    .do_sub (do_sub),
    .sum    (sum),
    .cy     (cy)
  );

  nr_step_flags u_flags (
    .out_bit (out_bit),
    .m_cur   (flg_q.m),
    .cy      (cy),
    .q_new   (q_new),
    .t_new   (t_new)
  );

  // Next state: load wins over step
  always_comb begin
    flg_d = flg_q;
    rem_d = rem_q;
    if (load_i) begin
      flg_d = '{m: m_i, q: q_i, t: t_i};
    end else if (step_i) begin
      flg_d = '{m: flg_q.m, q: q_new, t: t_new};
      rem_d = sum;
    end
  end

  assign upd_en = load_i | step_i;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      flg_q <= DFLAGS_ZERO;
      rem_q <= '0;
    end else if (upd_en) begin
      flg_q <= flg_d;
      rem_q <= rem_d;
    end
  end

  assign rem_o = rem_q;
  assign m_o   = flg_q.m;
  assign q_o   = flg_q.q;
  assign t_o   = flg_q.t;
endmodule

// File: rtl/nr_div_step_chk.sv
module nr_div_step_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         step_i,
  input logic         load_i,
  input logic         m_i,
  input logic         q_i,
  input logic         t_i,
  input logic [W-1:0] divisor_i,
  input logic [W-1:0] rem_i,
  input logic [W-1:0] rem_o,
  input logic         m_o,
  input logic         q_o,
  input logic         t_o
);
  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> ($stable(rem_o) && $stable(m_o) && $stable(q_o) && $stable(t_o)));

  // R2
  load_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && load_i |=> (m_o == $past(m_i) && q_o == $past(q_i) && t_o == $past(t_i) && $stable(rem_o)));

  // R9
  m_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> $stable(m_o));

  // R8
  t_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && (step_i && !load_i) |=> (t_o == (q_o == m_o)));

  // R4
  shift_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && (step_i && !load_i && divisor_i == '0)
      |=> (rem_o == {$past(rem_i[W-2:0]), $past(t_o)}));
endmodule

bind nr_div_step nr_div_step_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .step_i    (step_i),
  .load_i    (load_i),
  .m_i       (m_i),
  .q_i       (q_i),
  .t_i       (t_i),
  .divisor_i (divisor_i),
  .rem_i     (rem_i),
  .rem_o     (rem_o),
  .m_o       (m_o),
  .q_o       (q_o),
  .t_o       (t_o)
);

// File: tb/tb_nr_div_step.sv
module tb_nr_div_step;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_i, load_i, m_i, q_i, t_i;
  logic [31:0] divisor_i, rem_i, rem_o;
  logic        m_o, q_o, t_o;

  int checks = 0;
  int failures = 0;
  bit armed = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] rem;
    logic        m, q, t;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  logic [31:0] mdl_rem = '0;
  logic        mdl_m = 1'b0, mdl_q = 1'b0, mdl_t = 1'b0;

  always #2 clk = ~clk;

  nr_div_step dut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .load_i(load_i),
    .m_i(m_i), .q_i(q_i), .t_i(t_i), .divisor_i(divisor_i), .rem_i(rem_i),
    .rem_o(rem_o), .m_o(m_o), .q_o(q_o), .t_o(t_o)
  );

  // Monitor: compares the item queued for the edge just taken
  always @(posedge clk) begin
    #1;
    if (armed) begin
      exp_t e;
      armed = 1'b0;
      e = sbq.pop_front();
      checks++;
      if (rem_o !== e.rem || m_o !== e.m || q_o !== e.q || t_o !== e.t) begin
        failures++;
        $display("FAIL %s: rem=%h m=%b q=%b t=%b expected rem=%h m=%b q=%b t=%b",
                 e.tag, rem_o, m_o, q_o, t_o, e.rem, e.m, e.q, e.t);
      end
    end
  end

  // Driver: one strobe cycle, expected result from the requirement formulas
  task automatic apply(input logic stp, input logic ld, input logic lm, input logic lq,
                       input logic lt, input logic [31:0] r, input logic [31:0] d,
                       input string tag);
    exp_t e;
    logic [31:0] sh;
    logic [32:0] wide;
    logic cb, nq;
    @(negedge clk);
    step_i = stp; load_i = ld; m_i = lm; q_i = lq; t_i = lt;
    rem_i = r; divisor_i = d;
    if (ld) begin
      mdl_m = lm; mdl_q = lq; mdl_t = lt;
    end else if (stp) begin
      sh = {r[30:0], mdl_t};
      if (mdl_q == mdl_m) begin
        mdl_rem = sh - d;
        cb = (sh < d);
      end else begin
        wide = {1'b0, sh} + {1'b0, d};
        mdl_rem = wide[31:0];
        cb = wide[32];
      end
      nq = r[31] ^ mdl_m ^ cb;
      mdl_q = nq;
      mdl_t = (nq == mdl_m);
    end
    e.rem = mdl_rem; e.m = mdl_m; e.q = mdl_q; e.t = mdl_t; e.tag = tag;
    sbq.push_back(e);
    armed = 1'b1;
    @(negedge clk);
    step_i = 1'b0; load_i = 1'b0;
  endtask

  // R12: full unsigned division, quotient collected from T
  task automatic long_div(input logic [31:0] hi, input logic [31:0] lo,
                          input logic [31:0] d);
    logic [31:0] lw, cur, quo, ref_q;
    logic [63:0] num;
    lw = lo; cur = hi; quo = '0;
    apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, "R2 setup");
    for (int i = 0; i < 32; i++) begin
      apply(1'b0, 1'b1, mdl_m, mdl_q, lw[31], 32'h0, 32'h0, "R2 bit");
      lw = {lw[30:0], 1'b0};
      apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, cur, d, "R12 step");
      cur = mdl_rem;
      quo = {quo[30:0], t_o};
    end
    num = {hi, lo};
    ref_q = 32'(num / {32'h0, d});
    checks++;
    if (quo !== ref_q) begin
      failures++;
      $display("FAIL R12: quotient=%h expected=%h", quo, ref_q);
    end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    step_i = 1'b0; load_i = 1'b0; m_i = 1'b0; q_i = 1'b0; t_i = 1'b0;
    divisor_i = '0; rem_i = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (rem_o !== 32'h0 || m_o !== 1'b0 || q_o !== 1'b0 || t_o !== 1'b0) begin
      failures++;
      $display("FAIL R1: rem=%h m=%b q=%b t=%b expected all zero", rem_o, m_o, q_o, t_o);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (rem_o !== 32'h0 || m_o !== 1'b0 || q_o !== 1'b0 || t_o !== 1'b0) begin
      failures++;
      $display("FAIL R1 after release: rem=%h m=%b q=%b t=%b expected all zero",
               rem_o, m_o, q_o, t_o);
    end

    apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'hDEAD_BEEF, 32'h5, "R2 load");
    apply(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h1234_5678, 32'h9, "R10 idle");
    apply(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_ABCD, 32'h3, "R3 load beats step");
    // R4: zero divisor isolates the shift, T=1 enters bit 0
    apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0, 32'h0, "R2");
    apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h4000_0001, 32'h0, "R4 shift");
    // old Q=0, M=0: subtract
    apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, "R2");
    apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0010, 32'h3, "R5 R7 R8 sub q0m0");
    // old Q=0, M=1: add
    apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0, 32'h0, "R2");
    apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h8000_0005, 32'hFFFF_FFF0, "R6 R7 R8 R9 add q0m1");
    // old Q=1, M=0: add
    apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0, "R2");
    apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h7000_0000, 32'h2000_0000, "R6 R7 add q1m0");
    // old Q=1, M=1: subtract
    apply(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0, 32'h0, "R2");
    apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'hC000_0000, 32'hF000_0000, "R5 R7 R9 sub q1m1");
    // R11: subtract wraps below zero
    apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, "R2");
    apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h5, "R11 sub wrap");
    // R11: add wraps past 2^32
    apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0, 32'h0, "R2");
    apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h7FFF_FFFF, 32'h2, "R11 add wrap");
    apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h7, "R10 idle after step");

    long_div(32'h0, 32'd1000, 32'd7);
    long_div(32'h3, 32'h1234_5678, 32'h10);
    long_div(32'h0001_2345, 32'h89AB_CDEF, 32'hFFFF_FFFF);
    long_div(32'h0, 32'hFFFF_FFFF, 32'h1);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule